// File: doc/BRIEF.md
# Delayed Read Transaction Tracker

This block sits on the target side of a shared bus and turns slow memory reads into split transactions. When a bus master issues a read aimed at memory and no transaction is held, the tracker records the address and the command, answers the master with Retry in that same cycle, and starts an internal memory read. The master is then free to leave the bus, and it comes back later with the same request.

Only one such transaction can be held. While the slot is in use, every read that does not match the recorded request is sent away with Retry and starts nothing. A matching read that arrives before the memory data is also retried. Once the data has arrived, the matching read completes in the cycle it is presented, with no wait states, and the slot becomes free again. If the master does not come back within a programmable number of cycles, the held data is discarded and the slot is released. Commands that are not memory reads get no response from this block.

Top module: `dly_rd_tracker`

## Requirements
- R1: After reset the slot is empty, `mem_rd_o` is low, and neither `rsp_retry_o` nor `rsp_done_o` is asserted.
- R2: A memory read that arrives while the slot is empty gets `rsp_retry_o` in the same cycle. In the next cycle `mem_rd_o` is high and `mem_addr_o` carries the request address.
- R3: A command that is not a memory read gets neither Retry nor completion, and it starts no memory read.
- R4: `mem_rd_o` stays high, with a stable address, until a cycle in which `mem_gnt_i` is high. It is low from the following cycle, and each transaction issues exactly one memory read.
- R5: While the memory read is in flight, every memory read is retried, including one that matches the held request.
- R6: While the slot is occupied, a memory read whose address differs from the held one is retried, starts no memory read and leaves the held request unchanged.
- R7: A request matches only when both the address and the command equal the held values. The same address with a different read command is retried.
- R8: When the data is held, a matching read gets `rsp_done_o` in the same cycle, with `rsp_data_o` equal to the memory data and no Retry. The slot is then free, so a following new read opens a new transaction.
- R9: A held transaction that sees no matching read during the first `discard_cycles_i`+1 cycles after the data arrives is dropped. A later read with the same address and command is then retried and starts a new memory read.
- R10: A matching read in the last cycle before the discard is still completed with the held data.
- R11: The memory read commands are the 4-bit codes 0x6, 0xC and 0xE. Each of them opens a transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Master request present this cycle |
| req_addr_i | input | AW | Request address |
| req_cmd_i | input | 4 | Request command code |
| rsp_retry_o | output | 1 | Terminate the request with Retry |
| rsp_done_o | output | 1 | Request completes this cycle |
| rsp_data_o | output | DW | Read data, valid with `rsp_done_o` |
| discard_cycles_i | input | TW | Discard limit for held data, in cycles |
| mem_rd_o | output | 1 | Internal memory read request |
| mem_addr_o | output | AW | Internal memory read address |
| mem_gnt_i | input | 1 | Memory accepts the read request |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_rdata_i | input | DW | Memory read data |

## Verification
The hardest case to reach from the ports is the boundary between completion and discard. A matching retry has to land on exactly the last cycle the data is held, and on the cycle after it, so the bench sets a small discard limit and counts clock edges from the cycle that returns the memory data. Proving that a mismatched read while the slot is busy leaves the held request untouched also needs a later step: the original request must still complete with the original data.

// File: rtl/dly_rd_pkg.sv
package dly_rd_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PEND  = 2'd1,
        ST_READY = 2'd2
    } slot_st_e;

    localparam logic [CMD_W-1:0] CMD_MRD      = 4'h6;
    localparam logic [CMD_W-1:0] CMD_MRD_MULT = 4'hC;
    localparam logic [CMD_W-1:0] CMD_MRD_LINE = 4'hE;

    function automatic logic is_mem_read(input logic [CMD_W-1:0] c);
        return (c == CMD_MRD) || (c == CMD_MRD_MULT) || (c == CMD_MRD_LINE);
    endfunction

endpackage

// File: rtl/dly_rd_match.sv
module dly_rd_match
    import dly_rd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    req_addr_i,
    input  logic [CMD_W-1:0] req_cmd_i,
    input  logic [AW-1:0]    held_addr_i,
    input  logic [CMD_W-1:0] held_cmd_i,
    output logic             is_rd_o,
    output logic             hit_o
);
    always_comb begin
        is_rd_o = is_mem_read(req_cmd_i);
        hit_o   = (req_addr_i == held_addr_i) && (req_cmd_i == held_cmd_i);
    end
endmodule

// File: rtl/dly_rd_discard.sv
module dly_rd_discard #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run_i && (cnt_q != limit_i)) begin
            cnt_d = cnt_q + 1'b1;
        end
        expire_o = run_i && (cnt_q == limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dly_rd_tracker.sv
module dly_rd_tracker
    import dly_rd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [CMD_W-1:0] req_cmd_i,
    output logic             rsp_retry_o,
    output logic             rsp_done_o,
    output logic [DW-1:0]    rsp_data_o,
    input  logic [TW-1:0]    discard_cycles_i,
    output logic             mem_rd_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [DW-1:0]    mem_rdata_i
);
    typedef struct packed {
        slot_st_e         st;
        logic             issued;
        logic [AW-1:0]    addr;
        logic [CMD_W-1:0] cmd;
        logic [DW-1:0]    data;
    } slot_t;

    slot_t    cur_q, nxt_d;
    slot_st_e st_q;
    logic     is_rd, hit, expire;
    logic     retry_c, done_c;

    assign st_q = cur_q.st;

    dly_rd_match #(.AW(AW)) u_match (
        .req_addr_i  (req_addr_i),
        .req_cmd_i   (req_cmd_i),
        .held_addr_i (cur_q.addr),
        .held_cmd_i  (cur_q.cmd),
        .is_rd_o     (is_rd),
        .hit_o       (hit)
    );

    dly_rd_discard #(.TW(TW)) u_discard (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (st_q == ST_READY),
        .limit_i  (discard_cycles_i),
        .expire_o (expire)
    );

    always_comb begin
        nxt_d   = cur_q;
        retry_c = 1'b0;
        done_c  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid_i && is_rd) begin
                    retry_c      = 1'b1;
                    nxt_d.st     = ST_PEND;
                    nxt_d.issued = 1'b0;
                    nxt_d.addr   = req_addr_i;
                    nxt_d.cmd    = req_cmd_i;
                end
            end
            ST_PEND: begin
                if (req_valid_i && is_rd) begin
                    retry_c = 1'b1;
                end
                if (!cur_q.issued && mem_gnt_i) begin
                    nxt_d.issued = 1'b1;
                end
                if (cur_q.issued && mem_rvalid_i) begin
                    nxt_d.st   = ST_READY;
                    nxt_d.data = mem_rdata_i;
                end
            end
            ST_READY: begin
                if (req_valid_i && is_rd) begin
                    if (hit) done_c  = 1'b1;
                    else     retry_c = 1'b1;
                end
                if (done_c || expire) begin
                    nxt_d.st   = ST_IDLE;
                    nxt_d.data = '0;
                end
            end
            default: begin
                nxt_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, issued: 1'b0, addr: '0, cmd: '0, data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rsp_retry_o = retry_c;
    assign rsp_done_o  = done_c;
    assign rsp_data_o  = done_c ? cur_q.data : '0;
    assign mem_rd_o    = (st_q == ST_PEND) && !cur_q.issued;
    assign mem_addr_o  = cur_q.addr;

endmodule

// File: rtl/dly_rd_tracker_chk.sv
module dly_rd_tracker_chk
    import dly_rd_pkg::*;
#(
    parameter int AW = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic [CMD_W-1:0] req_cmd_i,
    input logic             rsp_retry_o,
    input logic             rsp_done_o,
    input logic             mem_rd_o,
    input logic             mem_gnt_i,
    input logic [AW-1:0]    mem_addr_o,
    input slot_st_e         st_q
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_rd_o);

    assert_first_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && req_valid_i && is_mem_read(req_cmd_i))
        |-> (rsp_retry_o && !rsp_done_o));

    assert_nonread_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !is_mem_read(req_cmd_i)) |-> (!rsp_retry_o && !rsp_done_o));

    assert_mem_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !mem_gnt_i) |=> (mem_rd_o && $stable(mem_addr_o)));

    assert_mem_rd_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && mem_gnt_i) |=> !mem_rd_o);

    assert_pending_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PEND && req_valid_i && is_mem_read(req_cmd_i)) |-> rsp_retry_o);

    assert_done_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done_o |-> (!rsp_retry_o && req_valid_i && st_q == ST_READY));

    assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done_o |=> (st_q == ST_IDLE));
endmodule

bind dly_rd_tracker dly_rd_tracker_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_cmd_i   (req_cmd_i),
    .rsp_retry_o (rsp_retry_o),
    .rsp_done_o  (rsp_done_o),
    .mem_rd_o    (mem_rd_o),
    .mem_gnt_i   (mem_gnt_i),
    .mem_addr_o  (mem_addr_o),
    .st_q        (st_q)
);

// File: tb/dly_rd_tracker_tb_top.sv
module dly_rd_tracker_tb_top;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid_i = 1'b0;
    logic [AW-1:0] req_addr_i = '0;
    logic [3:0]    req_cmd_i = '0;
    logic          rsp_retry_o, rsp_done_o;
    logic [DW-1:0] rsp_data_o;
    logic [TW-1:0] discard_cycles_i = 8'd20;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic          mem_gnt_i = 1'b0;
    logic          mem_rvalid_i = 1'b0;
    logic [DW-1:0] mem_rdata_i = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dly_rd_tracker #(.AW(AW), .DW(DW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_cmd_i(req_cmd_i),
        .rsp_retry_o(rsp_retry_o), .rsp_done_o(rsp_done_o), .rsp_data_o(rsp_data_o),
        .discard_cycles_i(discard_cycles_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
        .mem_gnt_i(mem_gnt_i), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic r_retry, r_done;
    logic [DW-1:0] r_data;

    // one-cycle request; sampled inside the cycle, returns at the next falling edge
    task automatic req(input logic [AW-1:0] a, input logic [3:0] c);
        req_valid_i = 1'b1; req_addr_i = a; req_cmd_i = c;
        #1;
        r_retry = rsp_retry_o; r_done = rsp_done_o; r_data = rsp_data_o;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // grant then return data; ends in the first cycle with data held
    task automatic serve(input logic [DW-1:0] d);
        mem_gnt_i = 1'b1;
        @(negedge clk);
        mem_gnt_i = 1'b0; mem_rvalid_i = 1'b1; mem_rdata_i = d;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk(mem_rd_o == 1'b0, "R1 mem_rd after reset", 64'(mem_rd_o), 0);
        chk(!rsp_retry_o && !rsp_done_o, "R1 responses after reset", {rsp_retry_o, rsp_done_o}, 0);
    endtask

    task automatic t_basic;
        req(32'hA000, 4'h6);
        chk(r_retry && !r_done, "R2 first attempt retried", {r_retry, r_done}, 2);
        chk(mem_rd_o && mem_addr_o == 32'hA000, "R2 memory read launched", mem_addr_o, 32'hA000);
        repeat (3) @(negedge clk);
        chk(mem_rd_o == 1'b1, "R4 held until grant", 64'(mem_rd_o), 1);
        mem_gnt_i = 1'b1;
        @(negedge clk);
        mem_gnt_i = 1'b0;
        chk(mem_rd_o == 1'b0, "R4 dropped after grant", 64'(mem_rd_o), 0);
        req(32'hA000, 4'h6);
        chk(r_retry && !r_done, "R5 matching read retried in flight", {r_retry, r_done}, 2);
        chk(mem_rd_o == 1'b0, "R4 single memory read", 64'(mem_rd_o), 0);
        mem_rvalid_i = 1'b1; mem_rdata_i = 32'hCAFE0001;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        req(32'hA000, 4'h6);
        chk(r_done && !r_retry, "R8 matching completes", {r_retry, r_done}, 1);
        chk(r_data == 32'hCAFE0001, "R8 completion data", r_data, 32'hCAFE0001);
        req(32'hB000, 4'h6);
        chk(r_retry, "R8 slot freed, new read retried", 64'(r_retry), 1);
        chk(mem_rd_o && mem_addr_o == 32'hB000, "R8 new transaction opened", mem_addr_o, 32'hB000);
        serve(32'h1);
        req(32'hB000, 4'h6);
        chk(r_done, "R8 cleanup completion", 64'(r_done), 1);
    endtask

    task automatic t_nonread;
        req(32'hC000, 4'h7);
        chk(!r_retry && !r_done, "R3 write gets no response", {r_retry, r_done}, 0);
        chk(mem_rd_o == 1'b0, "R3 write starts no read", 64'(mem_rd_o), 0);
        req(32'hC000, 4'h2);
        chk(!r_retry && !r_done && !mem_rd_o, "R3 io read ignored", {r_retry, r_done, mem_rd_o}, 0);
    endtask

    task automatic t_mismatch;
        req(32'hD000, 4'h6);
        serve(32'hBEEF0002);
        req(32'hD004, 4'h6);
        chk(r_retry && !r_done, "R6 other address retried", {r_retry, r_done}, 2);
        chk(mem_rd_o == 1'b0, "R6 no new memory read", 64'(mem_rd_o), 0);
        req(32'hD000, 4'hE);
        chk(r_retry && !r_done, "R7 other command retried", {r_retry, r_done}, 2);
        req(32'hD000, 4'h6);
        chk(r_done && r_data == 32'hBEEF0002, "R6 held request intact", r_data, 32'hBEEF0002);
    endtask

    task automatic t_cmds;
        logic [3:0] codes [3] = '{4'h6, 4'hC, 4'hE};
        for (int i = 0; i < 3; i++) begin
            req(32'hE000 + 32'(i), codes[i]);
            chk(r_retry && mem_rd_o, "R11 read code opens transaction", {r_retry, mem_rd_o}, 3);
            serve(32'h100 + 32'(i));
            req(32'hE000 + 32'(i), codes[i]);
            chk(r_done && r_data == 32'h100 + 32'(i), "R11 read code completes", r_data, 32'h100 + 32'(i));
        end
    endtask

    task automatic t_discard;
        discard_cycles_i = 8'd3;
        req(32'hF000, 4'h6);
        serve(32'h5555);
        repeat (3) @(negedge clk);
        req(32'hF000, 4'h6);
        chk(r_done && r_data == 32'h5555, "R10 completes on last held cycle", r_data, 32'h5555);
        req(32'hF000, 4'h6);
        serve(32'h6666);
        repeat (4) @(negedge clk);
        req(32'hF000, 4'h6);
        chk(r_retry && !r_done, "R9 discarded request retried", {r_retry, r_done}, 2);
        chk(mem_rd_o == 1'b1, "R9 new memory read after discard", 64'(mem_rd_o), 1);
        serve(32'h7777);
        req(32'hF000, 4'h6);
        chk(r_done && r_data == 32'h7777, "R9 fresh data after discard", r_data, 32'h7777);
        discard_cycles_i = 8'd20;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_basic;
        t_nonread;
        t_mismatch;
        t_cmds;
        t_discard;
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule